// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache

This block sits between the load/store port of a 32-bit processor and a word-organised main memory. It keeps recently used lines on chip. Its geometry comes from parameters. The default is 4 sets of 2 ways, each line holding 4 words, for 32 words in total. A 2-set, 4-way arrangement of the same size comes from changing two parameters. Stores only update the cached copy and mark the line dirty. Main memory is written only when a dirty line is evicted or flushed. A store that misses first brings the line in and then merges the new word.

Refills and evictions move one whole line as a burst of sequential words. Each word is held on the memory port for a fixed number of cycles. The processor keeps its request raised until the cache answers with a ready pulse. A flush request walks every line, writes back the dirty ones and then leaves the whole cache invalid. Three counters record first-look hits, misses and words moved to or from memory, so the statistics can be read when a program stops.

Top module: `dcache_top`

## Requirements
- R1: After reset every line is invalid and all three counters read zero. `cpuReady`, `flushDone`, `memRead` and `memWrite` are low.
- R2: Address bits [1:0] are ignored. Bits [3:2] pick the word in a line, bits [5:4] pick the set and bits [31:6] are the tag. Memory addresses always have bits [1:0] at zero.
- R3: A request that hits raises `cpuReady` in the same cycle it is presented. A read returns the cached word on `cpuRdata`. `hitCount` rises by one.
- R4: A miss whose victim is clean reads the 4 words of the line in ascending address order, starting at the line base. `cpuReady` rises in the 10th cycle of the request. `missCount` rises by one and `hitCount` does not change.
- R5: A store that hits changes only the cached word. Memory is not written, and a later read returns the stored value.
- R6: A miss whose victim is dirty first writes the victim's 4 words to the victim's own line address, then refills. `cpuReady` rises in the 18th cycle.
- R7: A store that misses refills the line, then merges the store data. Memory keeps its old value until the line is written back.
- R8: When every way of the set is valid, the victim is the way accessed least recently. Both hits and refills count as an access.
- R9: An invalid way in the set is filled before any valid way is evicted.
- R10: A flush writes back exactly the dirty lines and then invalidates every line. `flushDone` pulses in cycle 10 + 8 × (number of dirty lines). The next access to any address misses.
- R11: `memWordCount` rises by one for every word moved to or from memory.
- R12: Each word moves with `memRead` or `memWrite` held, and the address stable, for 2 cycles. `memLast` marks the final cycle. Memory commits writes and supplies read data in that final cycle. Read and write never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Access request, held until `cpuReady` |
| cpuWe | input | 1 | 1 for a store, 0 for a load |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid while `cpuReady` is high |
| cpuReady | output | 1 | Access completes this cycle |
| flushReq | input | 1 | Flush request, held until `flushDone` |
| flushDone | output | 1 | Flush completes this cycle |
| memRead | output | 1 | Burst read of a word in progress |
| memWrite | output | 1 | Burst write of a word in progress |
| memLast | output | 1 | Final cycle of the current word transfer |
| memAddr | output | 32 | Byte address of the current word |
| memWdata | output | 32 | Data for a write-back word |
| memRdata | input | 32 | Memory data, sampled when `memLast` is high |
| hitCount | output | 32 | Number of first-look hits |
| missCount | output | 32 | Number of misses |
| memWordCount | output | 32 | Number of words moved to or from memory |

## Verification
A hit answers in the very cycle the request is raised. A clean miss answers in cycle 10 and a dirty miss in cycle 18. A flush completes in cycle 10 plus 8 per dirty line. Memory words are counted and logged at the edge that closes each `memLast` cycle. The bench drives each request on a falling edge and samples 1 ns later in every cycle, so it measures these latencies exactly. It reads the counters, the transfer log and the memory model at the falling edge that follows completion, once every register on the path has settled.

// File: rtl/dcache_pkg.sv
`timescale 1ns/100ps
package dcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_FSCAN,
    ST_FDONE
  } ctrlStateT;

  // strobes from control to the storage arrays
  typedef struct packed {
    logic hitUpdate;  // touch hit way, merge store word
    logic fillWord;   // write memRdata into the op line
    logic fillDone;   // set valid/tag, clear dirty, touch op way
    logic wbDone;     // clear dirty of the op line
    logic invalAll;   // invalidate every line
  } cacheStrobeT;

endpackage

// File: rtl/dcache_data.sv
`timescale 1ns/100ps
module dcache_data
  import dcache_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WORDS = 4,
  parameter int WAYS  = 2,
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = 30 - OFF_W - IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  cacheStrobeT      strb,
  input  logic [IDX_W-1:0] lookSet,
  input  logic [TAG_W-1:0] lookTag,
  input  logic [OFF_W-1:0] lookOff,
  input  logic             cpuWe,
  input  logic [31:0]      cpuWdata,
  input  logic [IDX_W-1:0] opSet,
  input  logic [WAY_W-1:0] opWay,
  input  logic [OFF_W-1:0] opWord,
  input  logic [TAG_W-1:0] fillTag,
  input  logic [31:0]      memRdata,
  output logic             hit,
  output logic [31:0]      hitData,
  output logic [WAY_W-1:0] victimWay,
  output logic             victimDirty,
  output logic             opDirty,
  output logic [TAG_W-1:0] opTag,
  output logic [31:0]      opData
);

  logic [TAG_W-1:0] tagArr  [SETS][WAYS];
  logic [WAYS-1:0]  validArr[SETS];
  logic [WAYS-1:0]  dirtyArr[SETS];
  logic [WAY_W-1:0] ageArr  [SETS][WAYS];
  logic [31:0]      dataArr [SETS][WAYS][WORDS];

  logic [WAYS-1:0]  wayHit;
  logic [WAY_W-1:0] hitWay;
  logic             doTouch;
  logic [IDX_W-1:0] touchSet;
  logic [WAY_W-1:0] touchWay;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validArr[lookSet][w] && (tagArr[lookSet][w] == lookTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (wayHit[w]) hitWay = WAY_W'(w);
  end

  assign hit     = |wayHit;
  assign hitData = dataArr[lookSet][hitWay][lookOff];

  // oldest way, overridden by the lowest invalid way
  always_comb begin
    victimWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (ageArr[lookSet][w] == WAY_W'(WAYS - 1)) victimWay = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validArr[lookSet][w]) victimWay = WAY_W'(w);
  end

  assign victimDirty = validArr[lookSet][victimWay] && dirtyArr[lookSet][victimWay];
  assign opDirty     = validArr[opSet][opWay] && dirtyArr[opSet][opWay];
  assign opTag       = tagArr[opSet][opWay];
  assign opData      = dataArr[opSet][opWay][opWord];

  assign doTouch  = strb.hitUpdate || strb.fillDone;
  assign touchSet = strb.fillDone ? opSet : lookSet;
  assign touchWay = strb.fillDone ? opWay : hitWay;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          ageArr[s][w] <= WAY_W'(w);
          tagArr[s][w] <= '0;
        end
      end
    end else begin
      if (doTouch)
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay)
            ageArr[touchSet][w] <= '0;
          else if (ageArr[touchSet][w] < ageArr[touchSet][touchWay])
            ageArr[touchSet][w] <= ageArr[touchSet][w] + 1'b1;
        end
      if (strb.hitUpdate && cpuWe) dirtyArr[lookSet][hitWay] <= 1'b1;
      if (strb.fillDone) begin
        validArr[opSet][opWay] <= 1'b1;
        dirtyArr[opSet][opWay] <= 1'b0;
        tagArr[opSet][opWay]   <= fillTag;
      end
      if (strb.wbDone) dirtyArr[opSet][opWay] <= 1'b0;
      if (strb.invalAll)
        for (int s = 0; s < SETS; s++) begin
          validArr[s] <= '0;
          dirtyArr[s] <= '0;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.hitUpdate && cpuWe) dataArr[lookSet][hitWay][lookOff] <= cpuWdata;
    if (strb.fillWord) dataArr[opSet][opWay][opWord] <= memRdata;
  end

endmodule

// File: rtl/dcache_ctrl.sv
`timescale 1ns/100ps
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WORDS = 4,
  parameter int WAYS  = 2,
  parameter int BURST = 2,
  parameter int CNT_W = 32,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = 30 - OFF_W - IDX_W,
  localparam int TICK_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             flushReq,
  input  logic [IDX_W-1:0] lookSet,
  input  logic [TAG_W-1:0] lookTag,
  input  logic             hit,
  input  logic [WAY_W-1:0] victimWay,
  input  logic             victimDirty,
  input  logic             opDirty,
  input  logic [TAG_W-1:0] opTag,
  input  logic [31:0]      opData,
  output cacheStrobeT      strb,
  output logic [IDX_W-1:0] opSet,
  output logic [WAY_W-1:0] opWay,
  output logic [OFF_W-1:0] opWord,
  output logic [TAG_W-1:0] fillTag,
  output logic             cpuReady,
  output logic             flushDone,
  output logic             memRead,
  output logic             memWrite,
  output logic             memLast,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWdata,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount,
  output logic [CNT_W-1:0] memWordCount
);

  ctrlStateT         state;
  logic [TICK_W-1:0] tick;
  logic              retry, inFlush;
  logic              lastTick, lastWord, wayMax, setMax;
  ctrlStateT         advState;

  assign lastTick = (tick == TICK_W'(BURST - 1));
  assign lastWord = (opWord == OFF_W'(WORDS - 1));
  assign wayMax   = (opWay == WAY_W'(WAYS - 1));
  assign setMax   = (opSet == IDX_W'(SETS - 1));
  assign advState = (wayMax && setMax) ? ST_FDONE : ST_FSCAN;

  assign memRead  = (state == ST_FILL);
  assign memWrite = (state == ST_WBACK);
  assign memLast  = (memRead || memWrite) && lastTick;
  assign memAddr  = {(state == ST_WBACK) ? opTag : fillTag, opSet, opWord, 2'b00};
  assign memWdata = opData;

  always_comb begin
    strb      = '0;
    cpuReady  = 1'b0;
    flushDone = 1'b0;
    case (state)
      ST_IDLE: if (cpuReq && hit) begin
        cpuReady       = 1'b1;
        strb.hitUpdate = 1'b1;
      end
      ST_WBACK: strb.wbDone = lastTick && lastWord;
      ST_FILL: begin
        strb.fillWord = lastTick;
        strb.fillDone = lastTick && lastWord;
      end
      ST_FDONE: begin
        strb.invalAll = 1'b1;
        flushDone     = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      tick         <= '0;
      retry        <= 1'b0;
      inFlush      <= 1'b0;
      opSet        <= '0;
      opWay        <= '0;
      opWord       <= '0;
      fillTag      <= '0;
      hitCount     <= '0;
      missCount    <= '0;
      memWordCount <= '0;
    end else begin
      case (state)
        ST_IDLE:
          if (cpuReq) begin
            if (hit) begin
              retry <= 1'b0;
              if (!retry) hitCount <= hitCount + 1'b1;
            end else begin
              missCount <= missCount + 1'b1;
              retry     <= 1'b1;
              opSet     <= lookSet;
              opWay     <= victimWay;
              fillTag   <= lookTag;
              opWord    <= '0;
              tick      <= '0;
              state     <= victimDirty ? ST_WBACK : ST_FILL;
            end
          end else if (flushReq) begin
            inFlush <= 1'b1;
            opSet   <= '0;
            opWay   <= '0;
            state   <= ST_FSCAN;
          end
        ST_WBACK, ST_FILL:
          if (lastTick) begin
            tick         <= '0;
            opWord       <= opWord + 1'b1;
            memWordCount <= memWordCount + 1'b1;
            if (lastWord) begin
              if (state == ST_FILL) state <= ST_IDLE;
              else if (!inFlush) state <= ST_FILL;
              else begin
                state <= advState;
                if (wayMax) begin
                  opWay <= '0;
                  opSet <= opSet + 1'b1;
                end else opWay <= opWay + 1'b1;
              end
            end
          end else tick <= tick + 1'b1;
        ST_FSCAN:
          if (opDirty) begin
            state  <= ST_WBACK;
            opWord <= '0;
            tick   <= '0;
          end else begin
            state <= advState;
            if (wayMax) begin
              opWay <= '0;
              opSet <= opSet + 1'b1;
            end else opWay <= opWay + 1'b1;
          end
        ST_FDONE: begin
          inFlush <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dcache_top.sv
`timescale 1ns/100ps
module dcache_top
  import dcache_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WORDS = 4,
  parameter int WAYS  = 2,
  parameter int BURST = 2,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuWe,
  input  logic [31:0]      cpuAddr,
  input  logic [31:0]      cpuWdata,
  output logic [31:0]      cpuRdata,
  output logic             cpuReady,
  input  logic             flushReq,
  output logic             flushDone,
  output logic             memRead,
  output logic             memWrite,
  output logic             memLast,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount,
  output logic [CNT_W-1:0] memWordCount
);

  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = 30 - OFF_W - IDX_W;

  cacheStrobeT      strb;
  logic [OFF_W-1:0] lookOff, opWord;
  logic [IDX_W-1:0] lookSet, opSet;
  logic [TAG_W-1:0] lookTag, fillTag, opTag;
  logic [WAY_W-1:0] opWay, victimWay;
  logic             hit, victimDirty, opDirty;
  logic [31:0]      opData;
  logic             unusedByteSel;

  assign lookOff       = cpuAddr[OFF_W+1:2];
  assign lookSet       = cpuAddr[OFF_W+IDX_W+1:OFF_W+2];
  assign lookTag       = cpuAddr[31:OFF_W+IDX_W+2];
  assign unusedByteSel = ^cpuAddr[1:0];

  dcache_ctrl #(
    .SETS(SETS), .WORDS(WORDS), .WAYS(WAYS), .BURST(BURST), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .flushReq(flushReq),
    .lookSet(lookSet), .lookTag(lookTag), .hit(hit),
    .victimWay(victimWay), .victimDirty(victimDirty),
    .opDirty(opDirty), .opTag(opTag), .opData(opData),
    .strb(strb), .opSet(opSet), .opWay(opWay), .opWord(opWord), .fillTag(fillTag),
    .cpuReady(cpuReady), .flushDone(flushDone),
    .memRead(memRead), .memWrite(memWrite), .memLast(memLast),
    .memAddr(memAddr), .memWdata(memWdata),
    .hitCount(hitCount), .missCount(missCount), .memWordCount(memWordCount)
  );

  dcache_data #(
    .SETS(SETS), .WORDS(WORDS), .WAYS(WAYS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lookSet(lookSet), .lookTag(lookTag), .lookOff(lookOff),
    .cpuWe(cpuWe), .cpuWdata(cpuWdata),
    .opSet(opSet), .opWay(opWay), .opWord(opWord), .fillTag(fillTag),
    .memRdata(memRdata),
    .hit(hit), .hitData(cpuRdata),
    .victimWay(victimWay), .victimDirty(victimDirty),
    .opDirty(opDirty), .opTag(opTag), .opData(opData)
  );

endmodule

// File: rtl/dcache_checker.sv
`timescale 1ns/100ps
module dcache_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuReq,
  input logic             cpuReady,
  input logic             flushDone,
  input logic             memRead,
  input logic             memWrite,
  input logic             memLast,
  input logic [31:0]      memAddr,
  input logic [CNT_W-1:0] hitCount,
  input logic [CNT_W-1:0] memWordCount
);

  AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN) cpuReady |-> cpuReq); // R3
  AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rstN) cpuReady |-> (!memRead && !memWrite)); // R3
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rstN) cpuReq |=> (hitCount == $past(hitCount)) || (hitCount == $past(hitCount) + 1'b1)); // R3
  AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rstN) (memRead || memWrite) |-> (memAddr[1:0] == 2'b00)); // R2
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN) !(memRead && memWrite)); // R12
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rstN) ((memRead || memWrite) && !memLast) |=> ((memRead || memWrite) && $stable(memAddr))); // R12
  AST_WORD_COUNT: assert property (@(posedge clk) disable iff (!rstN) memLast |=> (memWordCount == $past(memWordCount) + 1'b1)); // R11
  AST_WORD_IDLE: assert property (@(posedge clk) disable iff (!rstN) !memLast |=> $stable(memWordCount)); // R11
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN) flushDone |-> (!memRead && !memWrite && !cpuReady)); // R10

endmodule

bind dcache_top dcache_checker #(.CNT_W(CNT_W)) chk (.*);

// File: tb/dcache_top_test.sv
`timescale 1ns/100ps
module dcache_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0, flushReq = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [31:0] cpuRdata, memAddr, memWdata, memRdata;
  logic        cpuReady, flushDone, memRead, memWrite, memLast;
  logic [31:0] hitCount, missCount, memWordCount;

  int nChecks = 0, nFails = 0;
  int expHits = 0, expMisses = 0, expWords = 0;
  bit finished = 0;

  logic [31:0] mem [1024];
  logic [31:0] logAddr [256];
  logic        logWr [256];
  int          logN = 0;

  always #2.5 clk = ~clk;

  dcache_top uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .flushReq(flushReq), .flushDone(flushDone),
    .memRead(memRead), .memWrite(memWrite), .memLast(memLast),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .hitCount(hitCount), .missCount(missCount), .memWordCount(memWordCount)
  );

  // memory model: initial word i holds A000_0000 | i
  assign memRdata = mem[memAddr[11:2]];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 32'hA000_0000 | i;
    end else if (memLast) begin
      if (memWrite) mem[memAddr[11:2]] <= memWdata;
      logAddr[logN[7:0]] <= memAddr;
      logWr[logN[7:0]]   <= memWrite;
      logN <= logN + 1;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // kind: 0 hit, 1 clean miss, 2 dirty miss
  task automatic access(input string req, input logic we, input logic [31:0] addr,
                        input logic [31:0] wdata, input logic [31:0] expData, input int kind);
    int cycles = 0;
    bit done = 0;
    logic [31:0] got = '0;
    int expCycles = (kind == 0) ? 1 : (kind == 1) ? 10 : 18;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata;
    while (!done && cycles < 200) begin
      #1;
      cycles++;
      if (cpuReady) begin
        got = cpuRdata;
        done = 1;
      end else @(negedge clk);
    end
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
    #1;
    if (kind == 0) expHits++;
    else begin
      expMisses++;
      expWords += (kind == 1) ? 4 : 8;
    end
    check(req, "latency", cycles, expCycles);
    if (!we) check(req, "read data", got, expData);
    check(req, "hitCount", hitCount, expHits);
    check(req, "missCount", missCount, expMisses);
    check("R11", "memWordCount", memWordCount, expWords);
  endtask

  task automatic flush(input string req, input int dirtyLines);
    int cycles = 0;
    bit done = 0;
    @(negedge clk);
    flushReq = 1'b1;
    while (!done && cycles < 400) begin
      #1;
      cycles++;
      if (flushDone) done = 1;
      else @(negedge clk);
    end
    @(negedge clk);
    flushReq = 1'b0;
    #1;
    expWords += 4 * dirtyLines;
    check(req, "flush latency", cycles, 10 + 8 * dirtyLines);
    check("R11", "memWordCount after flush", memWordCount, expWords);
    check(req, "hitCount unchanged by flush", hitCount, expHits);
  endtask

  task automatic checkLog(input string req, input int startN, input int pos,
                          input logic [31:0] base, input logic wr);
    for (int k = 0; k < 4; k++) begin
      check(req, "burst address", logAddr[(startN + pos + k) % 256], base + 32'(4 * k));
      check(req, "burst direction", {31'b0, logWr[(startN + pos + k) % 256]}, {31'b0, wr});
    end
  endtask

  task automatic testReset();
    check("R1", "hitCount", hitCount, 0);
    check("R1", "missCount", missCount, 0);
    check("R1", "memWordCount", memWordCount, 0);
    check("R1", "idle strobes", {28'b0, cpuReady, flushDone, memRead, memWrite}, 0);
  endtask

  task automatic testCleanMiss();
    int s = logN;
    access("R4", 1'b0, 32'h400, 0, 32'hA000_0100, 1);
    check("R12", "words in refill", logN - s, 4);
    checkLog("R4", s, 0, 32'h400, 1'b0);
  endtask

  task automatic testHits();
    access("R3", 1'b0, 32'h408, 0, 32'hA000_0102, 0);
    access("R2", 1'b0, 32'h40B, 0, 32'hA000_0102, 0);
    access("R3", 1'b0, 32'h40C, 0, 32'hA000_0103, 0);
  endtask

  task automatic testStoreHit();
    access("R5", 1'b1, 32'h404, 32'hDEAD_0001, 0, 0);
    check("R5", "memory untouched by store hit", mem[32'h101], 32'hA000_0101);
    access("R5", 1'b0, 32'h404, 0, 32'hDEAD_0001, 0);
  endtask

  task automatic testReplacement();
    int s;
    access("R9", 1'b0, 32'h440, 0, 32'hA000_0110, 1);
    access("R8", 1'b0, 32'h400, 0, 32'hA000_0100, 0);
    access("R8", 1'b0, 32'h480, 0, 32'hA000_0120, 1);
    access("R8", 1'b0, 32'h400, 0, 32'hA000_0100, 0);
    access("R8", 1'b0, 32'h4C0, 0, 32'hA000_0130, 1);
    s = logN;
    access("R6", 1'b0, 32'h500, 0, 32'hA000_0140, 2);
    check("R6", "words in dirty miss", logN - s, 8);
    checkLog("R6", s, 0, 32'h400, 1'b1);
    checkLog("R6", s, 4, 32'h500, 1'b0);
    check("R6", "written back store word", mem[32'h101], 32'hDEAD_0001);
    check("R6", "written back clean word", mem[32'h100], 32'hA000_0100);
  endtask

  task automatic testStoreMiss();
    access("R7", 1'b1, 32'h618, 32'hBEEF_0002, 0, 1);
    check("R7", "memory keeps old word", mem[32'h186], 32'hA000_0186);
    access("R7", 1'b0, 32'h618, 0, 32'hBEEF_0002, 0);
    access("R7", 1'b0, 32'h610, 0, 32'hA000_0184, 0);
  endtask

  task automatic testFlush();
    access("R10", 1'b1, 32'h4C8, 32'hCAFE_0003, 0, 0);
    flush("R10", 2);
    check("R10", "flushed set1 word", mem[32'h186], 32'hBEEF_0002);
    check("R10", "flushed set0 word", mem[32'h132], 32'hCAFE_0003);
    access("R10", 1'b0, 32'h4C8, 0, 32'hCAFE_0003, 1);
    flush("R10", 0);
    access("R10", 1'b0, 32'h618, 0, 32'hBEEF_0002, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    testReset();
    testCleanMiss();
    testHits();
    testStoreHit();
    testReplacement();
    testStoreMiss();
    testFlush();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule